// File: doc/BRIEF.md
# SPI Interrupt and DMA Request Generator

This block produces the interrupt status, the combined interrupt line and the per-channel transmit and receive DMA request lines of a multichannel SPI master. It does not decode addresses or run the serial link. The surrounding controller feeds it each channel's state as plain inputs:

- the enable bit, the DMA enables, the transmit-empty and receive-full flags;
- the turbo bit and the transfer mode;
- which channel owns the shared buffers, whether each direction of buffering is on, and the fill level of each buffer.

Register writes come in as single-cycle strobes with data. The block keeps its own copies of the thresholds and the word count.

Each channel has four status positions. Its transmit-empty event sits at bit 4n and its receive-full event at bit 4n+2. Bit 17 marks the end of a programmed word count. A status bit is set on the cycle its qualified condition rises. Software clears it by writing one to it. A status bit that is also enabled drives the interrupt output.

A system-test mode forces every implemented status bit to one and blocks clearing while it is active. The word counter is a three-state machine:

- `WC_OFF`: no count is loaded.
- `WC_RUN`: counting down.
- `WC_END`: the count reached zero.

Its transitions are:

- OFF→RUN and END→RUN: a level write with a nonzero count.
- RUN→OFF and END→OFF: a level write with a zero count.
- RUN→END: the last word completes.

A level write takes priority in every state.

Top module: `spi_irq_dma_gen`

## Requirements
- R1: After reset the status register, the enable register, the interrupt line, all DMA request lines and the remaining word count are zero.
- R2: A rising qualified transmit-empty condition on channel n sets status bit 4n. A rising qualified receive-full condition sets bit 4n+2. Both conditions require the channel to be enabled.
- R3: The enable register keeps only the bits of mask 0x3777F (0x1777F when the older variant is selected). All other written bits read as zero.
- R4: The interrupt output is high exactly when some status bit and the same enable bit are both one.
- R5: A status write clears each bit written as one. A set event in the same cycle wins over the clear.
- R6: While the test-mode input and the test-set input are both high, status writes clear nothing.
- R7: While the test-mode input and the test-set input are both high, every status bit in the mask becomes one, one cycle after they are first both high.
- R8: The transmit request of a channel is high one cycle after all of the following hold:
  - the channel is enabled;
  - transmit DMA is enabled;
  - transmit-empty is set;
  - the channel mode (bits [2n+1:2n] of `ch_mode`) is not receive-only.

  Mode encoding: 00 is full duplex, 01 is receive-only, 10 is transmit-only.
- R9: When the channel owns the buffers (`buf_ch`) and transmit buffering is on, the transmit request and the transmit-empty event also need the transmit level to be at or below the almost-empty threshold. That threshold is taken from bits 5:0 of a level write.
- R10: The receive request of a channel is high one cycle after all of the following hold:
  - the channel is enabled;
  - receive DMA is enabled;
  - receive-full is set;
  - the mode is not transmit-only.

  When the channel owns the buffers and receive buffering is on, the receive level must also be at or above the almost-full threshold, taken from bits 13:8 of a level write.
- R11: The receive-full status event is not produced while the channel's turbo input is high or its mode is transmit-only.
- R12: A level write loads a word count from bits 31:16. Each `word_done` pulse decrements the count while it runs. When a nonzero programmed count reaches zero, status bit 17 is set once. A zero count never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | NUM_CH | Channel enable |
| tx_dma_en | input | NUM_CH | Transmit DMA enable per channel |
| rx_dma_en | input | NUM_CH | Receive DMA enable per channel |
| tx_empty | input | NUM_CH | Transmit register empty flag |
| rx_full | input | NUM_CH | Receive register full flag |
| turbo | input | NUM_CH | Turbo mode per channel |
| ch_mode | input | 2*NUM_CH | Transfer mode per channel (00 duplex, 01 rx-only, 10 tx-only) |
| buf_ch | input | CH_IDX_W | Channel owning the shared buffers |
| tx_buf_on | input | 1 | Transmit buffering active for the owner |
| rx_buf_on | input | 1 | Receive buffering active for the owner |
| tx_level | input | LVL_W+1 | Transmit buffer fill level |
| rx_level | input | LVL_W+1 | Receive buffer fill level |
| lvl_wr | input | 1 | Level register write strobe |
| lvl_wdata | input | 32 | Level write data (thresholds and word count) |
| word_done | input | 1 | One word transferred on the owning channel |
| sts_wr | input | 1 | Status write strobe (write one to clear) |
| sts_wdata | input | 18 | Status write data |
| en_wr | input | 1 | Enable write strobe |
| en_wdata | input | 18 | Enable write data |
| test_mode | input | 1 | Module system-test mode |
| test_set | input | 1 | Test set bit |
| sts_q | output | 18 | Interrupt status register |
| en_q | output | 18 | Interrupt enable register |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | NUM_CH | Transmit DMA request per channel |
| rx_dma_req | output | NUM_CH | Receive DMA request per channel |
| words_left | output | WCNT_W | Remaining word count |

## Verification
The request lines are driven with each gating input removed in turn, so that a stuck term in the AND is exposed. They are also driven with buffering levels just off and just on each threshold, which separates a correct comparison from one that is off by one or has the wrong sense.

Status bits are raised on two channels, each in a distinct bit position, which tells the layout apart from a channel swap. They are cleared with and without the test hold, which tells the clear gating from plain write-one-to-clear. Turbo and transmit-only patterns are each applied alone to show that both suppress the receive event. The word counter is run to zero, pulsed past zero, and loaded with zero, which tells a single end event from a repeated one or a spurious one.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int STS_W   = 18;
    localparam int EOW_BIT = 17;

    typedef enum logic [1:0] {
        WC_OFF = 2'd0,
        WC_RUN = 2'd1,
        WC_END = 2'd2
    } wc_state_e;

    localparam logic [1:0] MODE_DUPLEX  = 2'b00;
    localparam logic [1:0] MODE_RX_ONLY = 2'b01;
    localparam logic [1:0] MODE_TX_ONLY = 2'b10;

    function automatic logic [STS_W-1:0] sts_mask(input bit newer);
        return newer ? 18'h3777F : 18'h1777F;
    endfunction
endpackage

// File: rtl/spi_chan_qual.sv
module spi_chan_qual
    import spi_irq_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tx_dma_en_i,
    input  logic             rx_dma_en_i,
    input  logic             tx_empty_i,
    input  logic             rx_full_i,
    input  logic             turbo_i,
    input  logic [1:0]       mode_i,
    input  logic             tx_buf_i,
    input  logic             rx_buf_i,
    input  logic [LVL_W:0]   tx_level_i,
    input  logic [LVL_W:0]   rx_level_i,
    input  logic [LVL_W-1:0] ael_i,
    input  logic [LVL_W-1:0] afl_i,
    output logic             tx_req_o,
    output logic             rx_req_o,
    output logic             tx_evt_o,
    output logic             rx_evt_o
);
    logic tx_lvl_ok, rx_lvl_ok;
    logic tx_cond, rx_cond;
    logic tx_prev, rx_prev;

    always_comb begin
        tx_lvl_ok = !tx_buf_i || (tx_level_i <= {1'b0, ael_i});
        rx_lvl_ok = !rx_buf_i || (rx_level_i >= {1'b0, afl_i});
        tx_cond   = en_i && tx_empty_i && (mode_i != MODE_RX_ONLY) && tx_lvl_ok;
        rx_cond   = en_i && rx_full_i && (mode_i != MODE_TX_ONLY) && rx_lvl_ok;
        tx_evt_o  = tx_cond && !tx_prev;
        rx_evt_o  = rx_cond && !turbo_i && !rx_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_prev  <= 1'b0;
            rx_prev  <= 1'b0;
            tx_req_o <= 1'b0;
            rx_req_o <= 1'b0;
        end else begin
            tx_prev  <= tx_cond;
            rx_prev  <= rx_cond && !turbo_i;
            tx_req_o <= tx_cond && tx_dma_en_i;
            rx_req_o <= rx_cond && rx_dma_en_i;
        end
    end

    assert_txreq_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_o |-> $past(en_i && tx_dma_en_i && tx_empty_i && mode_i != MODE_RX_ONLY));

    assert_rxreq_qual_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req_o |-> $past(en_i && rx_dma_en_i && rx_full_i && mode_i != MODE_TX_ONLY));
endmodule

// File: rtl/spi_wcnt_fsm.sv
module spi_wcnt_fsm
    import spi_irq_pkg::*;
#(
    parameter int WCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WCNT_W-1:0] load_val_i,
    input  logic              word_done_i,
    output logic [WCNT_W-1:0] left_o,
    output logic              eow_o
);
    wc_state_e state_q, state_d;
    logic      last_word;

    assign last_word = (left_o == WCNT_W'(1));

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = (load_val_i != '0) ? WC_RUN : WC_OFF;
        end else begin
            unique case (state_q)
                WC_OFF:  state_d = WC_OFF;
                WC_RUN:  if (word_done_i && last_word) state_d = WC_END;
                WC_END:  state_d = WC_END;
                default: state_d = WC_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WC_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 left_o <= '0;
        else if (load_i)                            left_o <= load_val_i;
        else if (state_q == WC_RUN && word_done_i)  left_o <= left_o - WCNT_W'(1);
    end

    assign eow_o = (state_q == WC_RUN) && (state_d == WC_END);

    assert_end_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WC_END) |-> (left_o == '0));

    assert_eow_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
        eow_o |=> !eow_o);
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter bit NEWER = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sts_wr_i,
    input  logic [STS_W-1:0] sts_wdata_i,
    input  logic             en_wr_i,
    input  logic [STS_W-1:0] en_wdata_i,
    input  logic             hold_i,
    input  logic [STS_W-1:0] set_i,
    output logic [STS_W-1:0] sts_o,
    output logic [STS_W-1:0] en_o,
    output logic             irq_o
);
    localparam logic [STS_W-1:0] MASK = sts_mask(NEWER);

    logic [STS_W-1:0] clr, frc, sts_d;

    always_comb begin
        clr   = (sts_wr_i && !hold_i) ? sts_wdata_i : '0;
        frc   = hold_i ? MASK : '0;
        sts_d = ((sts_o & ~clr) | set_i | frc) & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_o <= '0;
            en_o  <= '0;
        end else begin
            sts_o <= sts_d;
            if (en_wr_i) en_o <= en_wdata_i & MASK;
        end
    end

    assign irq_o = |(sts_o & en_o);

    assert_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> ((sts_o & MASK) == MASK));

    assert_noclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> ((sts_o & $past(sts_o)) == $past(sts_o)));
endmodule

// File: rtl/spi_irq_dma_gen.sv
module spi_irq_dma_gen
    import spi_irq_pkg::*;
#(
    parameter int NUM_CH   = 4,   // at most 4: four status bits per channel below bit 16
    parameter int LVL_W    = 6,
    parameter int WCNT_W   = 16,
    parameter bit NEWER    = 1'b1,
    localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     ch_en,
    input  logic [NUM_CH-1:0]     tx_dma_en,
    input  logic [NUM_CH-1:0]     rx_dma_en,
    input  logic [NUM_CH-1:0]     tx_empty,
    input  logic [NUM_CH-1:0]     rx_full,
    input  logic [NUM_CH-1:0]     turbo,
    input  logic [2*NUM_CH-1:0]   ch_mode,
    input  logic [CH_IDX_W-1:0]   buf_ch,
    input  logic                  tx_buf_on,
    input  logic                  rx_buf_on,
    input  logic [LVL_W:0]        tx_level,
    input  logic [LVL_W:0]        rx_level,
    input  logic                  lvl_wr,
    input  logic [31:0]           lvl_wdata,
    input  logic                  word_done,
    input  logic                  sts_wr,
    input  logic [STS_W-1:0]      sts_wdata,
    input  logic                  en_wr,
    input  logic [STS_W-1:0]      en_wdata,
    input  logic                  test_mode,
    input  logic                  test_set,
    output logic [STS_W-1:0]      sts_q,
    output logic [STS_W-1:0]      en_q,
    output logic                  irq,
    output logic [NUM_CH-1:0]     tx_dma_req,
    output logic [NUM_CH-1:0]     rx_dma_req,
    output logic [WCNT_W-1:0]     words_left
);
    localparam int AFL_LSB = 8;
    localparam int CNT_LSB = 16;

    logic [LVL_W-1:0]  ael_q, afl_q;
    logic [NUM_CH-1:0] tx_evt, rx_evt;
    logic              eow;
    logic [STS_W-1:0]  set_vec;
    logic              lvl_unused;

    assign lvl_unused = ^{lvl_wdata[AFL_LSB-1:LVL_W], lvl_wdata[CNT_LSB-1:AFL_LSB+LVL_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ael_q <= '0;
            afl_q <= '0;
        end else if (lvl_wr) begin
            ael_q <= lvl_wdata[LVL_W-1:0];
            afl_q <= lvl_wdata[AFL_LSB +: LVL_W];
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic own;
        assign own = (buf_ch == CH_IDX_W'(n));
        spi_chan_qual #(.LVL_W(LVL_W)) u_qual (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (ch_en[n]),
            .tx_dma_en_i(tx_dma_en[n]),
            .rx_dma_en_i(rx_dma_en[n]),
            .tx_empty_i (tx_empty[n]),
            .rx_full_i  (rx_full[n]),
            .turbo_i    (turbo[n]),
            .mode_i     (ch_mode[2*n +: 2]),
            .tx_buf_i   (own && tx_buf_on),
            .rx_buf_i   (own && rx_buf_on),
            .tx_level_i (tx_level),
            .rx_level_i (rx_level),
            .ael_i      (ael_q),
            .afl_i      (afl_q),
            .tx_req_o   (tx_dma_req[n]),
            .rx_req_o   (rx_dma_req[n]),
            .tx_evt_o   (tx_evt[n]),
            .rx_evt_o   (rx_evt[n])
        );
    end

    spi_wcnt_fsm #(.WCNT_W(WCNT_W)) u_wcnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (lvl_wr),
        .load_val_i (lvl_wdata[CNT_LSB +: WCNT_W]),
        .word_done_i(word_done),
        .left_o     (words_left),
        .eow_o      (eow)
    );

    always_comb begin
        set_vec = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            set_vec[4*n]     = tx_evt[n];
            set_vec[4*n + 2] = rx_evt[n];
        end
        set_vec[EOW_BIT] = eow && NEWER;
    end

    spi_irq_status #(.NEWER(NEWER)) u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .sts_wr_i   (sts_wr),
        .sts_wdata_i(sts_wdata),
        .en_wr_i    (en_wr),
        .en_wdata_i (en_wdata),
        .hold_i     (test_mode && test_set),
        .set_i      (set_vec),
        .sts_o      (sts_q),
        .en_o       (en_q),
        .irq_o      (irq)
    );

    assert_turbo_no_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (turbo[0] && !(test_mode && test_set) && !sts_q[2]) |=> !sts_q[2]);
endmodule

// File: tb/tb_spi_irq_dma_gen.sv
module tb_spi_irq_dma_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NUM_CH-1:0] ch_en = '0, tx_dma_en = '0, rx_dma_en = '0;
    logic [NUM_CH-1:0] tx_empty = '0, rx_full = '0, turbo = '0;
    logic [2*NUM_CH-1:0] ch_mode = '0;
    logic [1:0] buf_ch = '0;
    logic tx_buf_on = 0, rx_buf_on = 0;
    logic [6:0] tx_level = '0, rx_level = '0;
    logic lvl_wr = 0, word_done = 0, sts_wr = 0, en_wr = 0;
    logic [31:0] lvl_wdata = '0;
    logic [17:0] sts_wdata = '0, en_wdata = '0;
    logic test_mode = 0, test_set = 0;
    logic [17:0] sts_q, en_q;
    logic irq;
    logic [NUM_CH-1:0] tx_dma_req, rx_dma_req;
    logic [15:0] words_left;

    int n_chk = 0;
    int n_err = 0;

    spi_irq_dma_gen dut (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .tx_dma_en(tx_dma_en),
        .rx_dma_en(rx_dma_en), .tx_empty(tx_empty), .rx_full(rx_full),
        .turbo(turbo), .ch_mode(ch_mode), .buf_ch(buf_ch),
        .tx_buf_on(tx_buf_on), .rx_buf_on(rx_buf_on), .tx_level(tx_level),
        .rx_level(rx_level), .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata),
        .word_done(word_done), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .en_wr(en_wr), .en_wdata(en_wdata), .test_mode(test_mode),
        .test_set(test_set), .sts_q(sts_q), .en_q(en_q), .irq(irq),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .words_left(words_left)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(sts_q, 0, "R1 status"); chk(en_q, 0, "R1 enable");
        chk(irq, 0, "R1 irq"); chk({tx_dma_req, rx_dma_req}, 0, "R1 requests");
        chk(words_left, 0, "R1 words_left");
    endtask

    task automatic t_tx_req();
        ch_en[1] = 1; tx_dma_en[1] = 1; tx_empty[1] = 1; tick();
        chk(tx_dma_req, 4'b0010, "R8 tx request ch1");
        chk(sts_q, 18'h10, "R2 tx-empty at bit 4 for ch1");
        chk(irq, 0, "R4 irq off with enable zero");
        ch_mode[3:2] = 2'b01; tick();
        chk(tx_dma_req, 0, "R8 rx-only blocks tx request");
        ch_mode[3:2] = 2'b00; tx_dma_en[1] = 0; tick();
        chk(tx_dma_req, 0, "R8 tx dma disabled");
        tx_dma_en[1] = 1; tick();
        chk(tx_dma_req, 4'b0010, "R8 tx request restored");
    endtask

    task automatic t_enable_irq();
        en_wr = 1; en_wdata = 18'h3FFFF; tick(); en_wr = 0;
        chk(en_q, 18'h3777F, "R3 enable mask");
        chk(irq, 1, "R4 irq with enabled status");
        en_wr = 1; en_wdata = 18'h00004; tick(); en_wr = 0;
        chk(irq, 0, "R4 irq off when status bit not enabled");
        en_wr = 1; en_wdata = 18'h3FFFF; tick(); en_wr = 0;
    endtask

    task automatic t_w1c();
        sts_wr = 1; sts_wdata = 18'h10; tick(); sts_wr = 0;
        chk(sts_q, 0, "R5 write one clears bit 4");
        chk(irq, 0, "R4 irq drops after clear");
        // same-cycle set wins over clear
        tx_empty[1] = 0; tick();
        tx_empty[1] = 1; sts_wr = 1; sts_wdata = 18'h10; tick(); sts_wr = 0;
        chk(sts_q, 18'h10, "R5 set wins over clear");
        sts_wr = 1; sts_wdata = 18'h10; tick(); sts_wr = 0;
    endtask

    task automatic t_rx_turbo();
        ch_en[2] = 1; rx_full[2] = 1; turbo[2] = 1; tick();
        chk(sts_q[10], 0, "R11 turbo suppresses rx-full status");
        turbo[2] = 0; ch_mode[5:4] = 2'b10; tick();
        chk(sts_q[10], 0, "R11 tx-only suppresses rx-full status");
        ch_mode[5:4] = 2'b00; rx_dma_en[2] = 1; tick();
        chk(sts_q, 18'h400, "R2 rx-full at bit 10 for ch2");
        chk(rx_dma_req, 4'b0100, "R10 rx request ch2");
        ch_mode[5:4] = 2'b10; tick();
        chk(rx_dma_req, 0, "R10 tx-only blocks rx request");
        ch_mode[5:4] = 2'b00; tick();
        sts_wr = 1; sts_wdata = 18'h3FFFF; tick(); sts_wr = 0;
    endtask

    task automatic t_thresholds();
        lvl_wr = 1; lvl_wdata = 32'h0000_0803; tick(); lvl_wr = 0;
        buf_ch = 2'd2; rx_buf_on = 1; rx_level = 7'd7; tick();
        chk(rx_dma_req, 0, "R10 rx level below almost-full");
        rx_level = 7'd8; tick();
        chk(rx_dma_req, 4'b0100, "R10 rx level at almost-full");
        buf_ch = 2'd1; rx_buf_on = 0; tx_buf_on = 1; tx_level = 7'd4; tick();
        chk(tx_dma_req, 0, "R9 tx level above almost-empty");
        sts_wr = 1; sts_wdata = 18'h3FFFF; tick(); sts_wr = 0;
        tx_level = 7'd3; tick();
        chk(tx_dma_req, 4'b0010, "R9 tx level at almost-empty");
        chk(sts_q[4], 1, "R9 tx-empty event at threshold");
        tx_buf_on = 0;
        sts_wr = 1; sts_wdata = 18'h3FFFF; tick(); sts_wr = 0;
    endtask

    task automatic t_test_mode();
        test_mode = 1; test_set = 1; tick();
        chk(sts_q, 18'h3777F, "R7 test force sets masked bits");
        sts_wr = 1; sts_wdata = 18'h3FFFF; tick(); sts_wr = 0;
        chk(sts_q, 18'h3777F, "R6 clear ignored in test hold");
        test_set = 0; tick();
        sts_wr = 1; sts_wdata = 18'h3FFFF; tick(); sts_wr = 0;
        chk(sts_q, 0, "R5 clear works after hold released");
        test_mode = 0;
    endtask

    task automatic t_wcnt();
        lvl_wr = 1; lvl_wdata = 32'h0003_0000; tick(); lvl_wr = 0;
        chk(words_left, 3, "R12 count loaded");
        for (int i = 0; i < 2; i++) begin
            word_done = 1; tick(); word_done = 0; tick();
        end
        chk(sts_q[17], 0, "R12 no end event before zero");
        chk(words_left, 1, "R12 count decremented");
        word_done = 1; tick(); word_done = 0;
        chk(sts_q[17], 1, "R12 end event at zero");
        chk(words_left, 0, "R12 count at zero");
        sts_wr = 1; sts_wdata = 18'h20000; tick(); sts_wr = 0;
        word_done = 1; tick(); word_done = 0; tick();
        chk(sts_q[17], 0, "R12 no repeat event past zero");
        chk(words_left, 0, "R12 count holds at zero");
        lvl_wr = 1; lvl_wdata = 32'h0; tick(); lvl_wr = 0;
        word_done = 1; tick(); word_done = 0; tick();
        chk(sts_q[17], 0, "R12 zero count never fires");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        t_reset();
        t_tx_req();
        t_enable_irq();
        t_w1c();
        t_rx_turbo();
        t_thresholds();
        t_test_mode();
        t_wcnt();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule